// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the hazard controller of an in-order-issue, out-of-order-completion machine. It sits behind instruction decode and manages a small fixed set of unpipelined functional units: integer, load/store, floating add, multiply and divide. Each cycle decode may present one instruction. The instruction carries a target unit, a destination register and two source registers. The block decides whether the instruction issues in that cycle. After issue it steps the instruction through operand read, execution and result write, and it emits a one-cycle strobe for each of these events.

Each unit slot holds the instruction's registers, the producing unit of each source and a ready flag for each source. It also holds an issue sequence number, which is used to compare the ages of two slots. A result-status table records, for each register, which unit will write it next. The units' datapaths are not part of the block. Each is reduced to a fixed-latency countdown, and every latency is a parameter.

The decode stage holds its instruction while `iss_accept_o` is low, which stalls all younger instructions. The register file and the operand buses act on the read-grant and write-grant strobes.

Top module: `scoreboard_ctl`

## Requirements
- R1: An instruction is accepted (`iss_accept_o` high) in a cycle only if `iss_valid_i` is high, its unit is idle and no active instruction has the same destination register. Otherwise it is held.
- R2: A unit is busy from its issue cycle through its write cycle. An instruction waiting for that unit is accepted in the cycle after the write.
- R3: A unit requests its operand read no earlier than the cycle after issue, and only when both sources are available. A source written in a given cycle counts as available in that same cycle.
- R4: At most one read grant is given per cycle. When several units are ready, the one issued earliest wins, whatever its unit index.
- R5: `ex_start_o` for a unit pulses exactly one cycle after that unit's read grant.
- R6: A unit becomes eligible to write LAT cycles after its execute start. LAT is 1, 2, 4, 10 and 20 by default for units 0 to 4 (integer, load/store, add, multiply, divide).
- R7: At most one write grant is given per cycle, and the earliest-issued eligible unit wins. `wb_reg_o` carries the destination of the granted unit and is 0 when no grant is given.
- R8: A unit's write is held while any earlier-issued unit has not yet read a source equal to that destination. The write takes place in the cycle after that read.
- R9: After reset all units are idle, no strobe is active, and the first valid instruction is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Decoded instruction present |
| iss_fu_i | input | 3 | Target unit index (0 int, 1 load/store, 2 add, 3 multiply, 4 divide) |
| iss_dst_i | input | RW | Destination register |
| iss_src_j_i | input | RW | First source register |
| iss_src_k_i | input | RW | Second source register |
| iss_accept_o | output | 1 | Instruction issues this cycle |
| rd_grant_o | output | 5 | Per-unit operand read strobe |
| ex_start_o | output | 5 | Per-unit execution start strobe |
| wb_grant_o | output | 5 | Per-unit register write strobe |
| wb_reg_o | output | RW | Register written under the write strobe |

## Verification
The hardest situations to reach from the ports are those where two arbitration rules act in the same cycle. One is a write held back by an older, still-unread source. Another is two slots that become ready on the same producer write, where the older slot has the higher unit index. The stimulus reaches these cases by issuing a 20-cycle divide first. Short operations are then issued behind it in a chosen order, so that they pile up on the divide's result or finish early and wait. Every expected cycle is derived from the issue cycle plus the latency parameters.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int NFU  = 5;
  parameter int FUW  = 3;
  parameter int SEQW = $clog2(NFU) + 2;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_EX, PH_WB} phase_e;

  // a issued before b (modular sequence numbers, few in flight)
  function automatic logic seq_older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = b - a;
    return (d != '0) && !d[SEQW-1];
  endfunction
endpackage

// File: rtl/sb_age_arb.sv
module sb_age_arb import sb_pkg::*; (
  input  logic [NFU-1:0]           req_i,
  input  logic [NFU-1:0][SEQW-1:0] seq_i,
  output logic [NFU-1:0]           gnt_o
);
  always_comb begin
    for (int i = 0; i < NFU; i++) begin
      gnt_o[i] = req_i[i];
      for (int j = 0; j < NFU; j++)
        if (j != i && req_i[j] && seq_older(seq_i[j], seq_i[i])) gnt_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot import sb_pkg::*; #(
  parameter int RW  = 3,
  parameter int LAT = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            iss_i,
  input  logic [RW-1:0]   iss_dst_i,
  input  logic [RW-1:0]   iss_src_j_i,
  input  logic [RW-1:0]   iss_src_k_i,
  input  logic            iss_rj_i,
  input  logic            iss_rk_i,
  input  logic [FUW-1:0]  iss_qj_i,
  input  logic [FUW-1:0]  iss_qk_i,
  input  logic [SEQW-1:0] iss_seq_i,
  input  logic            wb_any_i,
  input  logic [FUW-1:0]  wb_fu_i,
  input  logic            rd_gnt_i,
  input  logic            wb_gnt_i,
  output logic            busy_o,
  output logic            wait_rd_o,
  output logic            rd_req_o,
  output logic            done_o,
  output logic            ex_start_o,
  output logic [RW-1:0]   fi_o,
  output logic [RW-1:0]   fj_o,
  output logic [RW-1:0]   fk_o,
  output logic [SEQW-1:0] seq_o
);
  localparam int CW = $clog2(LAT + 1);

  phase_e         phase_q;
  logic [CW-1:0]  cnt_q;
  logic           first_q;
  logic           rj_q, rk_q;
  logic [FUW-1:0] qj_q, qk_q;
  logic           hit_j, hit_k;

  assign hit_j      = wb_any_i && (wb_fu_i == qj_q);
  assign hit_k      = wb_any_i && (wb_fu_i == qk_q);
  assign busy_o     = (phase_q != PH_IDLE);
  assign wait_rd_o  = (phase_q == PH_RD);
  assign rd_req_o   = wait_rd_o && (rj_q || hit_j) && (rk_q || hit_k);
  assign done_o     = (phase_q == PH_WB);
  assign ex_start_o = (phase_q == PH_EX) && first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      first_q <= 1'b0;
      rj_q    <= 1'b0;
      rk_q    <= 1'b0;
      qj_q    <= '0;
      qk_q    <= '0;
      fi_o    <= '0;
      fj_o    <= '0;
      fk_o    <= '0;
      seq_o   <= '0;
    end else if (iss_i) begin
      phase_q <= PH_RD;
      fi_o    <= iss_dst_i;
      fj_o    <= iss_src_j_i;
      fk_o    <= iss_src_k_i;
      rj_q    <= iss_rj_i;
      rk_q    <= iss_rk_i;
      qj_q    <= iss_qj_i;
      qk_q    <= iss_qk_i;
      seq_o   <= iss_seq_i;
    end else begin
      unique case (phase_q)
        PH_RD: begin
          if (rd_gnt_i) begin
            phase_q <= PH_EX;
            cnt_q   <= CW'(LAT);
            first_q <= 1'b1;
            rj_q    <= 1'b0;
            rk_q    <= 1'b0;
          end else begin
            if (hit_j) rj_q <= 1'b1;
            if (hit_k) rk_q <= 1'b1;
          end
        end
        PH_EX: begin
          first_q <= 1'b0;
          if (cnt_q == CW'(1)) phase_q <= PH_WB;
          else cnt_q <= cnt_q - CW'(1);
        end
        PH_WB: if (wb_gnt_i) phase_q <= PH_IDLE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scoreboard_ctl.sv
module scoreboard_ctl import sb_pkg::*; #(
  parameter int NREG    = 8,
  parameter int RW      = $clog2(NREG),
  parameter int LAT_INT = 1,
  parameter int LAT_LS  = 2,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 10,
  parameter int LAT_DIV = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           iss_valid_i,
  input  logic [FUW-1:0] iss_fu_i,
  input  logic [RW-1:0]  iss_dst_i,
  input  logic [RW-1:0]  iss_src_j_i,
  input  logic [RW-1:0]  iss_src_k_i,
  output logic           iss_accept_o,
  output logic [NFU-1:0] rd_grant_o,
  output logic [NFU-1:0] ex_start_o,
  output logic [NFU-1:0] wb_grant_o,
  output logic [RW-1:0]  wb_reg_o
);
  logic [NFU-1:0]           busy, wait_rd, rd_req, done, war_blk, wb_cand;
  logic [NFU-1:0][RW-1:0]   fi, fj, fk;
  logic [NFU-1:0][SEQW-1:0] seq;
  logic [NREG-1:0]          rs_vld_q;
  logic [FUW-1:0]           rs_fu_q [NREG];
  logic [SEQW-1:0]          seq_q;
  logic                     wb_any;
  logic [FUW-1:0]           wb_fu;
  logic                     fu_ok, rj_new, rk_new;

  // issue decision
  assign fu_ok        = (32'(iss_fu_i) < NFU);
  assign iss_accept_o = iss_valid_i && fu_ok && !busy[iss_fu_i] && !rs_vld_q[iss_dst_i];
  assign rj_new = !rs_vld_q[iss_src_j_i] || (wb_any && wb_fu == rs_fu_q[iss_src_j_i]);
  assign rk_new = !rs_vld_q[iss_src_k_i] || (wb_any && wb_fu == rs_fu_q[iss_src_k_i]);

  for (genvar g = 0; g < NFU; g++) begin : g_fu
    localparam int LAT_G = (g == 0) ? LAT_INT : (g == 1) ? LAT_LS :
                           (g == 2) ? LAT_ADD : (g == 3) ? LAT_MUL : LAT_DIV;
    sb_fu_slot #(.RW(RW), .LAT(LAT_G)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .iss_i      (iss_accept_o && (iss_fu_i == FUW'(g))),
      .iss_dst_i  (iss_dst_i),
      .iss_src_j_i(iss_src_j_i),
      .iss_src_k_i(iss_src_k_i),
      .iss_rj_i   (rj_new),
      .iss_rk_i   (rk_new),
      .iss_qj_i   (rs_fu_q[iss_src_j_i]),
      .iss_qk_i   (rs_fu_q[iss_src_k_i]),
      .iss_seq_i  (seq_q),
      .wb_any_i   (wb_any),
      .wb_fu_i    (wb_fu),
      .rd_gnt_i   (rd_grant_o[g]),
      .wb_gnt_i   (wb_grant_o[g]),
      .busy_o     (busy[g]),
      .wait_rd_o  (wait_rd[g]),
      .rd_req_o   (rd_req[g]),
      .done_o     (done[g]),
      .ex_start_o (ex_start_o[g]),
      .fi_o       (fi[g]),
      .fj_o       (fj[g]),
      .fk_o       (fk[g]),
      .seq_o      (seq[g])
    );
  end

  // WAR hold: an older slot still has to read the old value of our destination
  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      war_blk[u] = 1'b0;
      for (int v = 0; v < NFU; v++)
        if (v != u && wait_rd[v] && seq_older(seq[v], seq[u]) &&
            (fj[v] == fi[u] || fk[v] == fi[u]))
          war_blk[u] = 1'b1;
    end
    wb_cand = done & ~war_blk;
  end

  sb_age_arb u_rd_arb (.req_i(rd_req),  .seq_i(seq), .gnt_o(rd_grant_o));
  sb_age_arb u_wb_arb (.req_i(wb_cand), .seq_i(seq), .gnt_o(wb_grant_o));

  always_comb begin
    wb_any   = |wb_grant_o;
    wb_fu    = '0;
    wb_reg_o = '0;
    for (int u = 0; u < NFU; u++)
      if (wb_grant_o[u]) begin
        wb_fu    = FUW'(u);
        wb_reg_o = fi[u];
      end
  end

  // result status table and sequence counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_vld_q <= '0;
      seq_q    <= '0;
      for (int r = 0; r < NREG; r++) rs_fu_q[r] <= '0;
    end else begin
      if (wb_any) rs_vld_q[wb_reg_o] <= 1'b0;
      if (iss_accept_o) begin
        rs_vld_q[iss_dst_i] <= 1'b1;
        rs_fu_q[iss_dst_i]  <= iss_fu_i;
        seq_q               <= seq_q + SEQW'(1);
      end
    end
  end
endmodule

// File: rtl/scoreboard_ctl_chk.sv
module scoreboard_ctl_chk import sb_pkg::*; #(
  parameter int RW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           iss_valid_i,
  input logic           iss_accept_o,
  input logic [NFU-1:0] rd_grant_o,
  input logic [NFU-1:0] ex_start_o,
  input logic [NFU-1:0] wb_grant_o,
  input logic [RW-1:0]  wb_reg_o
);
  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_accept_o |-> iss_valid_i); // R1
  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_grant_o)); // R4
  AST_EX_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_start_o == $past(rd_grant_o)); // R5
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wb_grant_o)); // R7
  AST_WB_REG_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_grant_o == '0) |-> (wb_reg_o == '0)); // R7
  AST_NO_READ_AND_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_grant_o & wb_grant_o) == '0); // R3
endmodule

bind scoreboard_ctl scoreboard_ctl_chk #(.RW(RW)) u_chk (.*);

// File: tb/scoreboard_ctl_test.sv
module scoreboard_ctl_test;
  localparam int RW = 3;
  localparam int L_INT = 1, L_LS = 2, L_ADD = 4, L_MUL = 10, L_DIV = 20;
  localparam int U_INT = 0, U_LS = 1, U_ADD = 2, U_MUL = 3, U_DIV = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iss_valid_i = 1'b0;
  logic [2:0]    iss_fu_i = '0;
  logic [RW-1:0] iss_dst_i = '0, iss_src_j_i = '0, iss_src_k_i = '0;
  logic          iss_accept_o;
  logic [4:0]    rd_grant_o, ex_start_o, wb_grant_o;
  logic [RW-1:0] wb_reg_o;

  int cyc = 0, n_chk = 0, n_fail = 0, multi_rd = 0, multi_wb = 0;
  int rd_at[5], ex_at[5], wb_at[5], wbr_at[5];

  scoreboard_ctl uut (.*);

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if ($countones(rd_grant_o) > 1) multi_rd++;
    if ($countones(wb_grant_o) > 1) multi_wb++;
    for (int u = 0; u < 5; u++) begin
      if (rd_grant_o[u]) rd_at[u] = cyc;
      if (ex_start_o[u]) ex_at[u] = cyc;
      if (wb_grant_o[u]) begin wb_at[u] = cyc; wbr_at[u] = int'(wb_reg_o); end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int fu, input int d, input int j, input int k, output int icyc);
    iss_fu_i = 3'(fu); iss_dst_i = RW'(d); iss_src_j_i = RW'(j); iss_src_k_i = RW'(k);
    iss_valid_i = 1'b1;
    #1;
    while (!iss_accept_o) begin @(negedge clk_i); #1; end
    icyc = cyc;
    @(negedge clk_i);
    iss_valid_i = 1'b0;
  endtask

  task automatic settle();
    repeat (45) @(negedge clk_i);
  endtask

  task automatic run_all();
    int c, c2, c3;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R9: idle after reset
    repeat (2) @(negedge clk_i);
    chk("R9 strobes", int'(rd_grant_o | ex_start_o | wb_grant_o), 0);
    chk("R9 no accept w/o valid", int'(iss_accept_o), 0);

    // R9 / R3 / R5 / R6 / R7: single integer op
    c = cyc;
    issue(U_INT, 1, 2, 3, c2);
    chk("R9 immediate accept", c2, c);
    settle();
    chk("R3 read after issue", rd_at[U_INT], c + 1);
    chk("R5 ex start", ex_at[U_INT], c + 2);
    chk("R6 int write", wb_at[U_INT], c + 2 + L_INT);
    chk("R7 wb reg", wbr_at[U_INT], 1);

    // R3: RAW with same-cycle bypass
    issue(U_MUL, 4, 0, 0, c);
    issue(U_ADD, 5, 4, 0, c2);
    settle();
    chk("R6 mul write", wb_at[U_MUL], c + 2 + L_MUL);
    chk("R3 read on producer write", rd_at[U_ADD], c + 2 + L_MUL);
    chk("R5 add ex", ex_at[U_ADD], c + 3 + L_MUL);
    chk("R6 add write", wb_at[U_ADD], c + 3 + L_MUL + L_ADD);
    chk("R7 add wb reg", wbr_at[U_ADD], 5);

    // R2: structural stall on busy adder
    issue(U_ADD, 1, 0, 0, c);
    issue(U_ADD, 2, 0, 0, c2);
    chk("R2 reissue after write", c2, c + 3 + L_ADD);
    settle();
    chk("R2 second read", rd_at[U_ADD], c2 + 1);

    // R1: WAW stall across units
    issue(U_DIV, 6, 0, 0, c);
    issue(U_MUL, 6, 0, 0, c2);
    chk("R1 waw stall", c2, c + 3 + L_DIV);
    settle();
    chk("R1 div wb reg", wbr_at[U_DIV], 6);
    chk("R1 mul after waw", wb_at[U_MUL], c2 + 2 + L_MUL);

    // R4: oldest-first read, older slot has higher index
    issue(U_DIV, 7, 0, 0, c);
    issue(U_MUL, 1, 7, 0, c2);
    issue(U_ADD, 2, 7, 0, c3);
    settle();
    chk("R4 older reads first", rd_at[U_MUL], c + 2 + L_DIV);
    chk("R4 younger reads next", rd_at[U_ADD], c + 3 + L_DIV);
    chk("R6 add after wait", wb_at[U_ADD], c + 4 + L_DIV + L_ADD);

    // R7: write conflict, older load/store beats lower-index integer
    issue(U_LS, 3, 0, 0, c);
    issue(U_INT, 2, 0, 0, c2);
    settle();
    chk("R7 older writes first", wb_at[U_LS], c + 2 + L_LS);
    chk("R7 younger writes next", wb_at[U_INT], c + 3 + L_LS);
    chk("R7 ls wb reg", wbr_at[U_LS], 3);

    // R8: WAR hold
    issue(U_DIV, 7, 0, 0, c);
    issue(U_MUL, 1, 7, 5, c2);
    issue(U_ADD, 5, 0, 0, c3);
    settle();
    chk("R8 add read early", rd_at[U_ADD], c + 3);
    chk("R8 reader", rd_at[U_MUL], c + 2 + L_DIV);
    chk("R8 write held", wb_at[U_ADD], c + 3 + L_DIV);
    chk("R8 mul write", wb_at[U_MUL], c + 3 + L_DIV + L_MUL);

    chk("R4 single read grant", multi_rd, 0);
    chk("R7 single write grant", multi_wb, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule